// File: doc/BRIEF.md
# Indexed Block Register Target for a Two-Wire Management Bus

This block is a target on an SMBus-style two-wire bus. It holds a small bank of 8-bit configuration bytes reached through indexed block transfers. A host writes a starting index, a byte count and then the data bytes, which land at consecutive indices. To read, the host writes only the index, issues a repeated start with the read bit set, and then receives a count byte followed by bytes taken in order from the index.

The 7-bit target address and a default clock-path mode both come from three-level strap inputs. They are sampled once, the first time the power-good input goes high. Both bus lines are oversampled by the fast system clock through synchronizers. START and STOP are recognised from SDA edges while SCL is high. The block drives SDA only as an open-drain pull-down request.

The configuration bytes drive the block's outputs: per-output enables, per-output fast-slew selects, an amplitude code, an effective PLL mode and an effective frequency code. The mode and frequency fields override the strapped or default values only while their software-enable bits are set.

Top module: `smb_idx_regs`

## Requirements
- R1: The target address is 1101011 when the address strap level is 0 (low), 1101100 when it is 1 (mid) and 1101101 when it is 2 (high). A matching address byte (address in bits 7:1, R/W in bit 0, 0 = write) is acknowledged by pulling SDA low during the ninth clock.
- R2: Both straps are sampled only on the first cycle after reset in which power-good is high. Later strap changes or power-good toggles have no effect on the address or on the mode readback.
- R3: A block write is address+W, index N, count X, then data bytes. Each of these bytes is acknowledged, and data byte k is stored at index (N+k) mod 8.
- R4: In a block write, data bytes beyond the count X are not acknowledged and not stored.
- R5: A block read is address+W, index N, repeated START, address+R. The target then sends the count byte, which is byte 7 bits 4:0 zero-extended, followed by bytes from index N, N+1 and so on, MSB first. It keeps sending while the host acknowledges and releases SDA after the host's NACK.
- R6: Byte 7 holds the read count in bits 4:0 (writable, reset value 8). Bits 7:5 read 0.
- R7: Bytes 4, 5 and 6 read 0xFF, 0x01 and 0x46, and writes to them change nothing.
- R8: The byte index is taken modulo 8: an index past byte 7 wraps to byte 0, and a written index of 9 addresses byte 1.
- R9: Byte 1 bits 7:6 read back the strapped mode code (level 0 → 00, 1 → 01, 2 → 11). Output pll_mode equals the strapped code unless byte 1 bit 5 is 1, in which case it equals byte 1 bits 4:3.
- R10: Output freq_sel is 00 unless byte 3 bit 5 is 1, in which case it equals byte 3 bits 4:3. Output amp_code is byte 1 bits 1:0 and resets to 10.
- R11: Output enable n and slew select n sit at bit positions 0, 2, 3, 4, 6, 7 (for n = 0..5) of bytes 0 and 2. They reset to 1. Bits 1 and 5 of bytes 0 and 2, byte 1 bit 2, and byte 3 bits 7:6 and 2:1 read 1. Byte 3 bit 0 is writable and resets to 1.
- R12: After an address byte that does not match, the target acknowledges nothing and stores nothing until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good; its first high level latches the straps |
| addr_lvl | input | 2 | Address strap level: 0 low, 1 mid, 2 high |
| mode_lvl | input | 2 | Mode strap level: 0 low, 1 mid, 2 high |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| oe_mask | output | 6 | Per-output enable, 1 = running |
| slew_fast | output | 6 | Per-output slew select, 1 = fast |
| pll_mode | output | 2 | Effective PLL mode code |
| freq_sel | output | 2 | Effective frequency code |
| amp_code | output | 2 | Output amplitude code |

## Verification
The bench aims at count handling at both ends. It sends a write with more data bytes than its count; a design that ignores the count would acknowledge and store the extra byte. It then shrinks the read count; a design that returns the stored count in the wrong place, or that starts data one index late, shows shifted readback. Writes that cross index 7 and an index of 9 expose a design that saturates or drops upper bits wrongly. Writes to fixed bytes, software-enable fields with the enable clear, foreign addresses and strap changes after power-good each show up as a changed output or a changed readback when the design lets them through.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;
  localparam int REG_N  = 8;
  localparam int IDX_W  = $clog2(REG_N);
  localparam int CNT_W  = 5;
  localparam int OUT_N  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TACK, ST_IGN
  } st_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
  } ph_e;

  function automatic logic [6:0] lvl_addr(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 7'b1101011;
      2'd1:    return 7'b1101100;
      default: return 7'b1101101;
    endcase
  endfunction

  function automatic logic [1:0] lvl_mode(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic int out_pos(input int n);
    return n + ((n >= 1) ? 1 : 0) + ((n >= 4) ? 1 : 0);
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
  import smb_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [6:0]       my_addr,
  input  logic [7:0]       rd_data,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             ignoring
);
  st_e              st, st_n;
  ph_e              ph, ph_n;
  logic [3:0]       bcnt, bcnt_n;
  logic [7:0]       sr, sr_n;
  logic [IDX_W-1:0] ptr, ptr_n;
  logic [7:0]       left, left_n;
  logic             is_rd, is_rd_n, first, first_n, oe_n, hack, hack_n;
  logic             wr_en_n;
  logic [IDX_W-1:0] wr_idx_n;
  logic [7:0]       wr_data_n;
  logic [7:0]       tx_byte;

  assign tx_byte = first ? {{(8-CNT_W){1'b0}}, cnt_val} : rd_data;

  always_comb begin
    st_n = st; ph_n = ph; bcnt_n = bcnt; sr_n = sr; ptr_n = ptr;
    left_n = left; is_rd_n = is_rd; first_n = first; oe_n = sda_oe;
    hack_n = hack; wr_en_n = 1'b0; wr_idx_n = wr_idx; wr_data_n = wr_data;
    if (stop_det) begin
      st_n = ST_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_RX; ph_n = PH_ADDR; bcnt_n = '0; oe_n = 1'b0;
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bcnt < 4'd8) begin
            sr_n   = {sr[6:0], sda_s};
            bcnt_n = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            st_n = ST_ACK; oe_n = 1'b1; is_rd_n = 1'b0;
            case (ph)
              PH_ADDR: begin
                if (sr[7:1] == my_addr) begin
                  is_rd_n = sr[0];
                  first_n = 1'b1;
                  ph_n    = PH_INDEX;
                end else begin
                  st_n = ST_IGN; oe_n = 1'b0;
                end
              end
              PH_INDEX: begin
                ptr_n = sr[IDX_W-1:0];
                ph_n  = PH_COUNT;
              end
              PH_COUNT: begin
                left_n = sr;
                ph_n   = PH_DATA;
              end
              default: begin
                if (left != 8'd0) begin
                  wr_en_n   = 1'b1;
                  wr_idx_n  = ptr;
                  wr_data_n = sr;
                  ptr_n     = ptr + 1'b1;
                  left_n    = left - 8'd1;
                end else begin
                  st_n = ST_IGN; oe_n = 1'b0;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bcnt_n = '0;
            if (is_rd) begin
              sr_n    = tx_byte;
              oe_n    = ~tx_byte[7];
              first_n = 1'b0;
              if (!first) ptr_n = ptr + 1'b1;
              st_n    = ST_TX;
            end else begin
              oe_n = 1'b0;
              st_n = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt == 4'd7) begin
              oe_n = 1'b0;
              st_n = ST_TACK;
            end else begin
              bcnt_n = bcnt + 4'd1;
              sr_n   = {sr[6:0], 1'b0};
              oe_n   = ~sr[6];
            end
          end
        end
        ST_TACK: begin
          if (scl_rise) begin
            hack_n = ~sda_s;
          end else if (scl_fall) begin
            if (hack) begin
              bcnt_n = '0;
              sr_n   = tx_byte;
              oe_n   = ~tx_byte[7];
              ptr_n  = ptr + 1'b1;
              st_n   = ST_TX;
            end else begin
              st_n = ST_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; ph <= PH_ADDR; bcnt <= '0; sr <= '0; ptr <= '0;
      left <= '0; is_rd <= 1'b0; first <= 1'b0; sda_oe <= 1'b0;
      hack <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      st <= st_n; ph <= ph_n; bcnt <= bcnt_n; sr <= sr_n; ptr <= ptr_n;
      left <= left_n; is_rd <= is_rd_n; first <= first_n; sda_oe <= oe_n;
      hack <= hack_n; wr_en <= wr_en_n; wr_idx <= wr_idx_n; wr_data <= wr_data_n;
    end
  end

  assign rd_idx   = ptr;
  assign ignoring = (st == ST_IGN);
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       strap_mode,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [CNT_W-1:0] cnt_val,
  output logic [OUT_N-1:0] oe_mask,
  output logic [OUT_N-1:0] slew_fast,
  output logic [1:0]       pll_mode,
  output logic [1:0]       freq_sel,
  output logic [1:0]       amp_code
);
  localparam logic [7:0] WM_OUT = 8'hDD, WM_B1 = 8'h3B, WM_B3 = 8'h39;
  localparam logic [7:0] FX_B1 = 8'h04, FX_B3 = 8'hC6;

  logic [7:0] b0, b1, b2, b3, b0_n, b1_n, b2_n, b3_n;
  logic [CNT_W-1:0] b7, b7_n;

  always_comb begin
    b0_n = b0; b1_n = b1; b2_n = b2; b3_n = b3; b7_n = b7;
    if (wr_en) begin
      case (wr_idx)
        3'd0: b0_n = (wr_data & WM_OUT) | ~WM_OUT;
        3'd1: b1_n = (wr_data & WM_B1) | FX_B1;
        3'd2: b2_n = (wr_data & WM_OUT) | ~WM_OUT;
        3'd3: b3_n = (wr_data & WM_B3) | FX_B3;
        3'd7: b7_n = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b0 <= 8'hFF; b1 <= 8'h06; b2 <= 8'hFF; b3 <= 8'hC7; b7 <= CNT_W'(8);
    end else begin
      b0 <= b0_n; b1 <= b1_n; b2 <= b2_n; b3 <= b3_n; b7 <= b7_n;
    end
  end

  always_comb begin
    case (rd_idx)
      3'd0: rd_data = b0;
      3'd1: rd_data = {strap_mode, b1[5:0]};
      3'd2: rd_data = b2;
      3'd3: rd_data = b3;
      3'd4: rd_data = 8'hFF;
      3'd5: rd_data = 8'h01;
      3'd6: rd_data = 8'h46;
      default: rd_data = {{(8-CNT_W){1'b0}}, b7};
    endcase
  end

  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    assign oe_mask[g]   = b0[out_pos(g)];
    assign slew_fast[g] = b2[out_pos(g)];
  end

  assign cnt_val  = b7;
  assign pll_mode = b1[5] ? b1[4:3] : strap_mode;
  assign freq_sel = b3[5] ? b3[4:3] : 2'b00;
  assign amp_code = b1[1:0];
endmodule

// File: rtl/smb_idx_regs.sv
module smb_idx_regs
  import smb_idx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_good,
  input  logic [1:0]       addr_lvl,
  input  logic [1:0]       mode_lvl,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_oe,
  output logic [OUT_N-1:0] oe_mask,
  output logic [OUT_N-1:0] slew_fast,
  output logic [1:0]       pll_mode,
  output logic [1:0]       freq_sel,
  output logic [1:0]       amp_code
);
  logic cap_done, cap_done_n;
  logic [1:0] addr_lvl_q, mode_lvl_q, addr_lvl_n, mode_lvl_n;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_data, wr_data;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [CNT_W-1:0] cnt_val;
  logic wr_en, fsm_ign;

  always_comb begin
    cap_done_n = cap_done; addr_lvl_n = addr_lvl_q; mode_lvl_n = mode_lvl_q;
    if (!cap_done && pwr_good) begin
      cap_done_n = 1'b1; addr_lvl_n = addr_lvl; mode_lvl_n = mode_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_done <= 1'b0; addr_lvl_q <= 2'd1; mode_lvl_q <= 2'd1;
    end else begin
      cap_done <= cap_done_n; addr_lvl_q <= addr_lvl_n; mode_lvl_q <= mode_lvl_n;
    end
  end

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  smb_target_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .my_addr(lvl_addr(addr_lvl_q)), .rd_data(rd_data), .cnt_val(cnt_val),
    .rd_idx(rd_idx), .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ignoring(fsm_ign));

  smb_reg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .strap_mode(lvl_mode(mode_lvl_q)),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .rd_data(rd_data), .cnt_val(cnt_val), .oe_mask(oe_mask),
    .slew_fast(slew_fast), .pll_mode(pll_mode), .freq_sel(freq_sel),
    .amp_code(amp_code));
endmodule

// File: rtl/smb_idx_regs_chk.sv
module smb_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_in,
  input logic       sda_oe,
  input logic       cap_done,
  input logic [1:0] addr_q,
  input logic [1:0] mode_q,
  input logic       wr_en,
  input logic       fsm_ign
);
  // R5: the target changes SDA only while SCL is low
  a_r5_oe_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in)) |-> $stable(sda_oe));
  // R2: the capture flag never drops once set
  a_r2_cap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(cap_done));
  // R2: strapped levels frozen after capture
  a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && $past(cap_done)) |-> ($stable(addr_q) && $stable(mode_q)));
  // R12: no pull-down while ignoring the bus
  a_r12_ignore_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_ign && $past(fsm_ign)) |-> !sda_oe);
  // R12: no store while ignoring the bus
  a_r12_ignore_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fsm_ign) |-> !wr_en);
  // R3: one store per data byte
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

bind smb_idx_regs smb_idx_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_oe(sda_oe),
  .cap_done(cap_done), .addr_q(addr_lvl_q), .mode_q(mode_lvl_q),
  .wr_en(wr_en), .fsm_ign(fsm_ign));

// File: tb/smb_idx_regs_tb.sv
module smb_idx_regs_tb;
  localparam int Q = 5;
  logic clk = 1'b0;
  logic rst_n, pwr_good, host_scl, host_sda;
  logic [1:0] addr_lvl, mode_lvl;
  logic sda_oe, sda_line;
  logic [5:0] oe_mask, slew_fast;
  logic [1:0] pll_mode, freq_sel, amp_code;
  int checks = 0, errors = 0, cycles = 0;
  logic cmp_en = 1'b0;
  logic [7:0] m [0:7];
  logic [1:0] m_mode;
  logic [6:0] cur_addr;
  logic [7:0] wdat [0:15];
  logic [7:0] rdat [0:15];

  always #2 clk = ~clk;
  assign sda_line = host_sda & ~sda_oe;

  smb_idx_regs u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_lvl(addr_lvl),
    .mode_lvl(mode_lvl), .scl_in(host_scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .oe_mask(oe_mask), .slew_fast(slew_fast), .pll_mode(pll_mode),
    .freq_sel(freq_sel), .amp_code(amp_code));

  function automatic logic [7:0] wmask(input int i);
    case (i) 0, 2: return 8'hDD; 1: return 8'h3B; 3: return 8'h39;
      7: return 8'h1F; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] fixv(input int i);
    case (i) 0, 2: return 8'h22; 1: return 8'h04; 3: return 8'hC6;
      4: return 8'hFF; 5: return 8'h01; 6: return 8'h46; default: return 8'h00; endcase
  endfunction
  function automatic logic [7:0] exp_rd(input int i);
    if (i == 1) return {m_mode, m[1][5:0]};
    return m[i];
  endfunction
  function automatic logic [5:0] pick(input logic [7:0] b);
    return {b[7], b[6], b[4], b[3], b[2], b[0]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock reference comparison while the bus is idle (R9 R10 R11)
  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (cmp_en && rst_n) begin
      checks++;
      if (oe_mask !== pick(m[0]) || slew_fast !== pick(m[2]) ||
          amp_code !== m[1][1:0] ||
          pll_mode !== (m[1][5] ? m[1][4:3] : m_mode) ||
          freq_sel !== (m[3][5] ? m[3][4:3] : 2'b00)) begin
        errors++;
        $display("FAIL R9/R10/R11 actual=%h_%h_%h_%h_%h expected=%h_%h_%h_%h_%h",
          oe_mask, slew_fast, amp_code, pll_mode, freq_sel,
          pick(m[0]), pick(m[2]), m[1][1:0], (m[1][5] ? m[1][4:3] : m_mode),
          (m[3][5] ? m[3][4:3] : 2'b00));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1; host_scl = 1; tick(Q); host_sda = 0; tick(Q); host_scl = 0; tick(Q);
  endtask
  task automatic bus_rstart();
    host_sda = 1; tick(Q); host_scl = 1; tick(Q); host_sda = 0; tick(Q); host_scl = 0; tick(Q);
  endtask
  task automatic bus_stop();
    host_sda = 0; tick(Q); host_scl = 1; tick(Q); host_sda = 1; tick(Q);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; tick(Q); host_scl = 1; tick(2*Q); host_scl = 0; tick(Q);
    end
    host_sda = 1; tick(Q); host_scl = 1; tick(Q); ack = ~sda_line;
    tick(Q); host_scl = 0; tick(Q);
  endtask
  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); host_scl = 1; tick(Q); b[i] = sda_line; tick(Q); host_scl = 0;
    end
    tick(Q); host_sda = ~give_ack; tick(Q); host_scl = 1; tick(2*Q);
    host_scl = 0; tick(Q); host_sda = 1;
  endtask

  task automatic do_reset(input logic [1:0] al, input logic [1:0] ml);
    cmp_en = 0; rst_n = 0; pwr_good = 0; host_scl = 1; host_sda = 1;
    addr_lvl = al; mode_lvl = ml;
    tick(4); rst_n = 1; tick(4); pwr_good = 1; tick(4);
    m[0] = 8'hFF; m[1] = 8'h06; m[2] = 8'hFF; m[3] = 8'hC7;
    m[4] = 8'hFF; m[5] = 8'h01; m[6] = 8'h46; m[7] = 8'h08;
    m_mode = (ml == 0) ? 2'b00 : (ml == 1) ? 2'b01 : 2'b11;
    cur_addr = (al == 0) ? 7'h6B : (al == 1) ? 7'h6C : 7'h6D;
    cmp_en = 1; tick(2);
  endtask

  task automatic wr_blk(input logic [6:0] a, input int n, input int cnt, input int nsend);
    logic ack;
    logic hit;
    hit = (a == cur_addr);
    cmp_en = 0;
    bus_start();
    send_byte({a, 1'b0}, ack); chk(hit ? "R1 addr ack" : "R12 foreign no ack", ack, hit);
    send_byte(8'(n), ack);     chk(hit ? "R3 index ack" : "R12 index no ack", ack, hit);
    send_byte(8'(cnt), ack);   chk(hit ? "R3 count ack" : "R12 count no ack", ack, hit);
    for (int k = 0; k < nsend; k++) begin
      send_byte(wdat[k], ack);
      chk((k < cnt) ? "R3 data ack" : "R4 extra no ack", ack, hit && (k < cnt));
      if (hit && k < cnt) m[(n + k) % 8] = (wdat[k] & wmask((n + k) % 8)) | fixv((n + k) % 8);
    end
    bus_stop(); tick(4); cmp_en = 1; tick(4);
  endtask

  task automatic rd_blk(input int n, input int nrd);
    logic ack;
    cmp_en = 0;
    bus_start();
    send_byte({cur_addr, 1'b0}, ack); chk("R5 addr W ack", ack, 1);
    send_byte(8'(n), ack);            chk("R5 index ack", ack, 1);
    bus_rstart();
    send_byte({cur_addr, 1'b1}, ack); chk("R5 addr R ack", ack, 1);
    for (int k = 0; k < nrd; k++) recv_byte(k != nrd - 1, rdat[k]);
    tick(2); chk("R5 release after NACK", sda_oe, 0);
    bus_stop(); tick(4); cmp_en = 1; tick(4);
  endtask

  task automatic rd_check(input string req, input int n, input int nrd);
    rd_blk(n, nrd);
    chk({req, " count byte"}, rdat[0], {3'b000, m[7][4:0]});
    for (int k = 1; k < nrd; k++) chk(req, rdat[k], exp_rd((n + k - 1) % 8));
  endtask

  initial begin
    do_reset(2'd1, 2'd1);
    // R10 R11 reset state
    chk("R10 amp reset", amp_code, 2'b10);
    chk("R11 oe reset", oe_mask, 6'h3F);
    chk("R9 mode strap mid", pll_mode, 2'b01);
    // R5 R6 R7 R9 full readback, count 8
    rd_check("R5 R6 R7 R9 readback", 0, 9);
    // R11 output enables cleared, reserved bits stay 1
    wdat[0] = 8'h00; wr_blk(cur_addr, 0, 1, 1);
    rd_check("R11 byte0 reserved ones", 0, 2);
    // R7 fixed bytes ignore writes
    wdat[0] = 8'h00; wdat[1] = 8'h00; wdat[2] = 8'h00;
    wr_blk(cur_addr, 4, 3, 3);
    rd_check("R7 fixed bytes", 4, 4);
    // R9 mode field without and with enable
    wdat[0] = 8'h19; wr_blk(cur_addr, 1, 1, 1);
    chk("R9 no enable keeps strap", pll_mode, 2'b01);
    chk("R10 amp written", amp_code, 2'b01);
    wdat[0] = 8'h39; wr_blk(cur_addr, 1, 1, 1);
    chk("R9 enable selects field", pll_mode, 2'b11);
    // R10 frequency field
    wdat[0] = 8'h10; wr_blk(cur_addr, 3, 1, 1);
    chk("R10 freq disabled", freq_sel, 2'b00);
    wdat[0] = 8'h30; wr_blk(cur_addr, 3, 1, 1);
    chk("R10 freq enabled", freq_sel, 2'b10);
    // R4 extra byte beyond count
    wdat[0] = 8'hFF; wdat[1] = 8'h00; wr_blk(cur_addr, 2, 1, 2);
    rd_check("R4 extra not stored", 2, 3);
    // R8 wrap from 7 to 0, and index 9
    wdat[0] = 8'h05; wdat[1] = 8'h7F; wr_blk(cur_addr, 7, 2, 2);
    rd_check("R8 R6 wrap readback", 7, 6);
    wdat[0] = 8'h02; wr_blk(cur_addr, 9, 1, 1);
    rd_check("R8 index nine", 9, 2);
    // R6 count upper bits
    wdat[0] = 8'hE3; wr_blk(cur_addr, 7, 1, 1);
    rd_check("R6 count masked", 7, 4);
    // R12 foreign address
    wdat[0] = 8'h00; wr_blk(7'h6D, 2, 1, 1);
    rd_check("R12 nothing stored", 2, 2);
    // R2 later strap change ignored
    addr_lvl = 2'd0; mode_lvl = 2'd2; pwr_good = 0; tick(4); pwr_good = 1; tick(4);
    wr_blk(7'h6B, 0, 0, 0);
    rd_check("R2 strap frozen", 1, 2);
    // R1 R9 low and high strap levels
    do_reset(2'd0, 2'd0);
    chk("R9 mode strap low", pll_mode, 2'b00);
    rd_check("R1 low address", 1, 2);
    do_reset(2'd2, 2'd2);
    chk("R9 mode strap high", pll_mode, 2'b11);
    rd_check("R1 high address", 5, 3);
    wr_blk(7'h6C, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule